// File: doc/BRIEF.md
# Synchronization State Machine Word Aligner

This block finds and holds the word boundary of an 8b/10b-coded receive stream. Each cycle it may accept one parallel word (10 or 20 bits wide). With the word come two flags from the downstream decoder: one for an invalid code group and one for a running-disparity error. The block compares an alignment pattern against every bit offset of a sliding window. The pattern's value and length are parameters, with the pattern compared least-significant bit first. A state machine with programmable thresholds turns those matches, and the decoder's error flags, into a sync flag and a boundary offset.

The machine has four states:

- **Hunting:** not synchronized.
- **Gathering:** collecting patterns at one offset.
- **Locked.**
- **Forgiving:** locked, but carrying errors.

Several patterns at a fixed offset bring the block into lock. A run of bad words takes it back to hunting. Each complete run of consecutive good words forgives one error, and when no errors remain the block is fully locked again. A word aligner or barrel shifter downstream uses the boundary output to slice the stream.

Top module: `sync_aligner`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `sync_ok` is 0 and `word_bnd` is 0, and the block is hunting.
- R2: A pattern hit at bit j of the current word means the window matches PATTERN, bit i against stream bit i of the candidate, ending at bit j. Stream order is word bit 0 first, and earlier words come first. Bits from before reset count as 0. Of several hits, the lowest j is taken.
- R3: While hunting, a word with no error flag and at least one hit loads `word_bnd` with the hit offset and counts as the first pattern. A hit on a word with an error flag is ignored.
- R4: While gathering, only a hit at the stored offset on an error-free word advances the pattern count. Hits at other offsets leave both the count and `word_bnd` unchanged. Reaching LOCK_CNT patterns in total enters the locked state.
- R5: While gathering, a word with either error flag sets the pattern count to zero. This happens even if the same word carries a hit at the stored offset.
- R6: `sync_ok` is 1 exactly while the block is locked or forgiving. All outputs change on the clock edge that accepts the word causing the change.
- R7: In the locked and forgiving states, each word with `sym_err` or `disp_err` set raises the error count by one. When the count reaches LOSS_CNT, the block returns to hunting with all counters cleared. `word_bnd` keeps its last value.
- R8: While forgiving, GOOD_CNT consecutive error-free words lower the error count by one. Any error word clears the good-word run, including on the word that would have completed it.
- R9: When the error count falls back to zero, the block is locked again. The next error word then starts counting from one.
- R10: Cycles with `word_vld` low change no state and no output, whatever the other inputs carry.
- R11: Once locked or forgiving, pattern hits at any offset do not move `word_bnd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_vld | input | 1 | A receive word is present this cycle |
| word_in | input | DATA_W | Receive word, bit 0 earliest |
| sym_err | input | 1 | Decoder flags the word as an invalid code group |
| disp_err | input | 1 | Decoder flags a running-disparity error on the word |
| sync_ok | output | 1 | Synchronization achieved (locked or forgiving) |
| word_bnd | output | $clog2(DATA_W) | Bit index within the word where the aligned pattern ends |

## Verification
Two functions can meet on the same word:

- **During gathering:** a pattern hit at the stored offset can arrive on a word the decoder flags as bad. The bench provokes this by sending a comma at the tracked offset with `sym_err` raised. It judges the result by showing that a full LOCK_CNT fresh patterns are needed afterwards.
- **While forgiving:** an error word can land exactly where a good-word run would have completed a decrement. The bench places the error on the GOOD_CNT-th word and counts the remaining errors until loss. With the wrong priority, sync would be dropped one error later.

A behavioural reference model in the bench follows both cases on every clock.

// File: rtl/sync_aligner_pkg.sv
// Package: shared state type for the word aligner.
// Assumes: nothing beyond IEEE 1800-2017.
package sync_aligner_pkg;

    // Alignment machine states
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,   // no alignment, searching any offset
        ST_GATHER = 2'd1,   // offset chosen, counting patterns toward lock
        ST_LOCKED = 2'd2,   // aligned, no outstanding errors
        ST_FORGIVE= 2'd3    // aligned, carrying errors being forgiven
    } sa_state_e;

endpackage

// File: rtl/sa_pattern_finder.sv
// Module: sa_pattern_finder
// Compares the alignment pattern against every bit offset of a window made
// of the current word plus enough history to hold a pattern that ends in the
// current word. Reports a hit vector indexed by the bit of the current word
// where the pattern ends, and the lowest such index.
// Assumes: bit 0 of a word is the earliest received; history starts at zero.
module sa_pattern_finder #(
    parameter int DATA_W  = 10,
    parameter int PAT_LEN = 10,
    parameter logic [PAT_LEN-1:0] PATTERN = 10'h17C
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       word_vld,
    input  logic [DATA_W-1:0]          word_in,
    output logic [DATA_W-1:0]          hit_vec,
    output logic                       hit_any,
    output logic [$clog2(DATA_W)-1:0]  hit_off
);
    localparam int OW     = $clog2(DATA_W);
    localparam int NW_RAW = (PAT_LEN + 2*DATA_W - 2) / DATA_W;
    localparam int NW     = (NW_RAW < 2) ? 2 : NW_RAW;
    localparam int HW     = (NW - 1) * DATA_W;
    localparam int WIN_W  = NW * DATA_W;
    localparam int SKEW   = WIN_W - PAT_LEN - DATA_W + 1;

    logic [HW-1:0]    hist_q;
    logic [WIN_W-1:0] win;

    assign win = {word_in, hist_q};

    // Keep the most recent HW stream bits for patterns spanning words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (word_vld) begin
            hist_q <= win[WIN_W-1 -: HW];
        end
    end

    // One comparator per end position inside the current word
    for (genvar o = 0; o < DATA_W; o++) begin : g_cmp
        assign hit_vec[o] = (win[SKEW + o +: PAT_LEN] == PATTERN);
    end

    assign hit_any = |hit_vec;

    // Lowest end position wins when several offsets match
    always_comb begin
        hit_off = '0;
        for (int o = DATA_W - 1; o >= 0; o--) begin
            if (hit_vec[o]) hit_off = OW'(o);
        end
    end

endmodule

// File: rtl/sa_sync_fsm.sv
// Module: sa_sync_fsm
// Acquisition and tracking state machine. Counts patterns at a fixed offset
// to reach lock, counts error words to lose it, and forgives one error per
// run of consecutive good words. Error flags dominate any coincident event.
// Assumes: thresholds are at least 1; one word per cycle when word_vld is high.
module sa_sync_fsm
    import sync_aligner_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int LOCK_CNT = 3,
    parameter int LOSS_CNT = 3,
    parameter int GOOD_CNT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       word_vld,
    input  logic                       word_bad,
    input  logic [DATA_W-1:0]          hit_vec,
    input  logic                       hit_any,
    input  logic [$clog2(DATA_W)-1:0]  hit_off,
    output logic                       sync_ok,
    output logic [$clog2(DATA_W)-1:0]  bnd,
    output sa_state_e                  state
);
    localparam int OW   = $clog2(DATA_W);
    localparam int PADW = 1 << OW;
    localparam int CW_P = $clog2(LOCK_CNT + 1);
    localparam int CW_E = $clog2(LOSS_CNT + 1);
    localparam int CW_G = $clog2(GOOD_CNT + 1);

    sa_state_e         st_q, st_d;
    logic [CW_P-1:0]   pat_q, pat_d;
    logic [CW_E-1:0]   err_q, err_d;
    logic [CW_G-1:0]   good_q, good_d;
    logic [OW-1:0]     bnd_q, bnd_d;
    logic [PADW-1:0]   hit_pad;
    logic              hit_here;

    assign hit_pad  = PADW'(hit_vec);
    assign hit_here = hit_pad[bnd_q];

    // Next-state and counter update for one accepted word
    always_comb begin
        st_d   = st_q;
        pat_d  = pat_q;
        err_d  = err_q;
        good_d = good_q;
        bnd_d  = bnd_q;
        if (word_vld) begin
            unique case (st_q)
                ST_HUNT: begin
                    if (!word_bad && hit_any) begin
                        bnd_d = hit_off;
                        if (LOCK_CNT == 1) begin
                            st_d  = ST_LOCKED;
                            pat_d = '0;
                        end else begin
                            st_d  = ST_GATHER;
                            pat_d = CW_P'(1);
                        end
                    end
                end
                ST_GATHER: begin
                    if (word_bad) begin
                        pat_d = '0;
                    end else if (hit_here) begin
                        if (pat_q + CW_P'(1) == CW_P'(LOCK_CNT)) begin
                            st_d  = ST_LOCKED;
                            pat_d = '0;
                        end else begin
                            pat_d = pat_q + CW_P'(1);
                        end
                    end
                end
                ST_LOCKED: begin
                    if (word_bad) begin
                        good_d = '0;
                        if (LOSS_CNT == 1) begin
                            st_d  = ST_HUNT;
                            err_d = '0;
                        end else begin
                            st_d  = ST_FORGIVE;
                            err_d = CW_E'(1);
                        end
                    end
                end
                ST_FORGIVE: begin
                    if (word_bad) begin
                        good_d = '0;
                        if (err_q + CW_E'(1) == CW_E'(LOSS_CNT)) begin
                            st_d  = ST_HUNT;
                            err_d = '0;
                            pat_d = '0;
                        end else begin
                            err_d = err_q + CW_E'(1);
                        end
                    end else if (good_q + CW_G'(1) == CW_G'(GOOD_CNT)) begin
                        good_d = '0;
                        err_d  = err_q - CW_E'(1);
                        if (err_q == CW_E'(1)) st_d = ST_LOCKED;
                    end else begin
                        good_d = good_q + CW_G'(1);
                    end
                end
                default: st_d = ST_HUNT;
            endcase
        end
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_HUNT;
            pat_q  <= '0;
            err_q  <= '0;
            good_q <= '0;
            bnd_q  <= '0;
        end else begin
            st_q   <= st_d;
            pat_q  <= pat_d;
            err_q  <= err_d;
            good_q <= good_d;
            bnd_q  <= bnd_d;
        end
    end

    assign sync_ok = (st_q == ST_LOCKED) || (st_q == ST_FORGIVE);
    assign bnd     = bnd_q;
    assign state   = st_q;

endmodule

// File: rtl/sync_aligner.sv
// Module: sync_aligner (top)
// Word-boundary acquisition for an 8b/10b stream: a pattern finder over all
// bit offsets feeding a threshold-driven sync state machine.
// Assumes: DATA_W is 10 or 20; decoder flags are aligned with word_in.
module sync_aligner
    import sync_aligner_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int PAT_LEN  = 10,
    parameter logic [PAT_LEN-1:0] PATTERN = 10'h17C,
    parameter int LOCK_CNT = 3,
    parameter int LOSS_CNT = 3,
    parameter int GOOD_CNT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       word_vld,
    input  logic [DATA_W-1:0]          word_in,
    input  logic                       sym_err,
    input  logic                       disp_err,
    output logic                       sync_ok,
    output logic [$clog2(DATA_W)-1:0]  word_bnd
);
    localparam int OW = $clog2(DATA_W);

    logic [DATA_W-1:0] hit_vec;
    logic              hit_any;
    logic [OW-1:0]     hit_off;
    logic              word_bad;
    sa_state_e         fsm_state;

    assign word_bad = sym_err | disp_err;

    sa_pattern_finder #(
        .DATA_W  (DATA_W),
        .PAT_LEN (PAT_LEN),
        .PATTERN (PATTERN)
    ) u_find (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .word_in  (word_in),
        .hit_vec  (hit_vec),
        .hit_any  (hit_any),
        .hit_off  (hit_off)
    );

    sa_sync_fsm #(
        .DATA_W   (DATA_W),
        .LOCK_CNT (LOCK_CNT),
        .LOSS_CNT (LOSS_CNT),
        .GOOD_CNT (GOOD_CNT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .word_bad (word_bad),
        .hit_vec  (hit_vec),
        .hit_any  (hit_any),
        .hit_off  (hit_off),
        .sync_ok  (sync_ok),
        .bnd      (word_bnd),
        .state    (fsm_state)
    );

endmodule

// File: rtl/sync_aligner_chk.sv
// Module: sync_aligner_chk
// Temporal checks on the aligner's ports and state, bound to every instance.
// Assumes: synchronous active-low reset.
module sync_aligner_chk
    import sync_aligner_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      word_vld,
    input logic                      sym_err,
    input logic                      disp_err,
    input logic                      sync_ok,
    input logic [$clog2(DATA_W)-1:0] word_bnd,
    input sa_state_e                 fsm_state
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!sync_ok && word_bnd == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> ($stable(sync_ok) && $stable(word_bnd)));

    // R11
    lock_bnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ok |=> $stable(word_bnd));

    // R6
    sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_ok) |-> $past(word_vld && !sym_err && !disp_err));

    // R7
    sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_ok) |-> $past(word_vld && (sym_err || disp_err)));

    // R5
    gather_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_GATHER && word_vld && (sym_err || disp_err))
        |=> (fsm_state == ST_GATHER));

endmodule

bind sync_aligner sync_aligner_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_vld  (word_vld),
    .sym_err   (sym_err),
    .disp_err  (disp_err),
    .sync_ok   (sync_ok),
    .word_bnd  (word_bnd),
    .fsm_state (fsm_state)
);

// File: tb/sync_aligner_tb.sv
// Bench: behavioural reference model on bit queues, compared every clock,
// plus directed checks at the points named by the requirements.
module sync_aligner_tb;
    localparam int DATA_W  = 10;
    localparam int PAT_LEN = 10;
    localparam logic [PAT_LEN-1:0] PATTERN = 10'h17C;
    localparam int LOCK_N  = 3;
    localparam int LOSS_N  = 3;
    localparam int GOOD_N  = 4;
    localparam int OW      = $clog2(DATA_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              word_vld = 1'b0;
    logic [DATA_W-1:0] word_in = '0;
    logic              sym_err = 1'b0;
    logic              disp_err = 1'b0;
    logic              sync_ok;
    logic [OW-1:0]     word_bnd;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    // model state: 0 hunt, 1 gather, 2 locked, 3 forgiving
    int  m_st, m_pat, m_err, m_good, m_bnd;
    bit  hq[$];
    bit  txq[$];
    int  pushed;
    bit  fill_b;

    sync_aligner #(
        .DATA_W(DATA_W), .PAT_LEN(PAT_LEN), .PATTERN(PATTERN),
        .LOCK_CNT(LOCK_N), .LOSS_CNT(LOSS_N), .GOOD_CNT(GOOD_N)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
        .sym_err(sym_err), .disp_err(disp_err),
        .sync_ok(sync_ok), .word_bnd(word_bnd)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_pat = 0; m_err = 0; m_good = 0; m_bnd = 0;
        hq.delete();
        for (int i = 0; i < PAT_LEN - 1; i++) hq.push_back(1'b0);
    endtask

    task automatic model_lose();
        m_st = 0; m_pat = 0; m_err = 0; m_good = 0;
    endtask

    task automatic model_step(input logic [DATA_W-1:0] w, input bit bad);
        bit c[$];
        bit hm[DATA_W];
        int first;
        c = hq;
        for (int i = 0; i < DATA_W; i++) c.push_back(w[i]);
        first = -1;
        for (int j = 0; j < DATA_W; j++) begin
            bit m;
            m = 1;
            for (int i = 0; i < PAT_LEN; i++)
                if (c[j + i] != PATTERN[i]) m = 0;
            hm[j] = m;
            if (m && first < 0) first = j;
        end
        while (c.size() > PAT_LEN - 1) void'(c.pop_front());
        hq = c;
        case (m_st)
            0: if (!bad && first >= 0) begin
                m_bnd = first;
                if (LOCK_N == 1) m_st = 2;
                else begin m_st = 1; m_pat = 1; end
            end
            1: if (bad) m_pat = 0;
               else if (hm[m_bnd]) begin
                   m_pat++;
                   if (m_pat == LOCK_N) begin m_st = 2; m_pat = 0; end
               end
            2: if (bad) begin
                m_err = 1; m_good = 0;
                if (m_err == LOSS_N) model_lose(); else m_st = 3;
            end
            default: if (bad) begin
                m_good = 0; m_err++;
                if (m_err == LOSS_N) model_lose();
            end else begin
                m_good++;
                if (m_good == GOOD_N) begin
                    m_good = 0; m_err--;
                    if (m_err == 0) m_st = 2;
                end
            end
        endcase
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic tick(input bit vld, input logic [DATA_W-1:0] w,
                        input bit se, input bit de, input string req);
        word_vld = vld; word_in = w; sym_err = se; disp_err = de;
        if (vld) model_step(w, se | de);
        @(posedge clk);
        @(negedge clk);
        check(sync_ok == ((m_st >= 2) ? 1'b1 : 1'b0), {req, " sync_ok"},
              int'(sync_ok), (m_st >= 2) ? 1 : 0);
        check(word_bnd == OW'(m_bnd), {req, " word_bnd"}, int'(word_bnd), m_bnd);
    endtask

    task automatic push_fill();
        txq.push_back(fill_b); fill_b = ~fill_b; pushed++;
    endtask

    task automatic send_word(input bit se, input bit de, input string req);
        logic [DATA_W-1:0] w;
        while (txq.size() < DATA_W) push_fill();
        for (int i = 0; i < DATA_W; i++) w[i] = txq.pop_front();
        tick(1'b1, w, se, de, req);
    endtask

    task automatic send_all(input bit se, input bit de, input string req);
        while (txq.size() > 0) send_word(se, de, req);
    endtask

    // place a pattern so that its last bit falls on bit 'off' of a word
    task automatic comma_at(input int off, input bit se, input string req);
        while (((pushed + PAT_LEN - 1) % DATA_W) != off) push_fill();
        for (int i = 0; i < PAT_LEN; i++) begin
            txq.push_back(PATTERN[i]); pushed++;
        end
        send_all(se, 1'b0, req);
    endtask

    task automatic goods(input int n, input string req);
        for (int k = 0; k < n; k++) send_word(1'b0, 1'b0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        pushed = 0; fill_b = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        check(sync_ok == 1'b0, "R1 reset sync_ok", int'(sync_ok), 0);
        check(word_bnd == '0, "R1 reset word_bnd", int'(word_bnd), 0);
        rst_n = 1'b1;
        tick(1'b0, '0, 1'b0, 1'b0, "R1 first cycle");

        // R10 idle cycles with junk on the data lines
        for (int k = 0; k < 3; k++) tick(1'b0, 10'h17C, 1'b1, 1'b1, "R10 idle");

        // R2 R3 first pattern ending at bit 2 of a word
        comma_at(2, 1'b0, "R3 hunt");
        check(word_bnd == OW'(2), "R3 boundary load", int'(word_bnd), 2);
        check(sync_ok == 1'b0, "R3 not yet synced", int'(sync_ok), 0);

        // R4 hit elsewhere ignored, then two more at offset 2
        comma_at(5, 1'b0, "R4 other offset");
        check(word_bnd == OW'(2), "R4 boundary kept", int'(word_bnd), 2);
        comma_at(2, 1'b0, "R4 gather");
        check(sync_ok == 1'b0, "R4 two patterns only", int'(sync_ok), 0);
        comma_at(2, 1'b0, "R4 gather");
        check(sync_ok == 1'b1, "R4 lock after three", int'(sync_ok), 1);

        // R11 hits while locked do not move the boundary
        comma_at(7, 1'b0, "R11 locked hit");
        check(word_bnd == OW'(2), "R11 boundary fixed", int'(word_bnd), 2);

        // R8 R9 forgiveness
        send_word(1'b1, 1'b0, "R8 error");
        goods(3, "R8 partial run");
        send_word(1'b0, 1'b1, "R8 run reset");
        goods(GOOD_N, "R8 forgive");
        goods(GOOD_N, "R9 back to lock");
        send_word(1'b1, 1'b0, "R9 fresh count");
        send_word(1'b1, 1'b0, "R9 fresh count");
        check(sync_ok == 1'b1, "R9 count restarted", int'(sync_ok), 1);
        goods(GOOD_N, "R8 forgive");
        goods(GOOD_N - 1, "R8 coincide");
        send_word(1'b1, 1'b0, "R8 error on run end");
        goods(GOOD_N - 1, "R8 coincide");
        send_word(1'b0, 1'b1, "R8 error on run end");
        check(sync_ok == 1'b0, "R8 error wins over decrement", int'(sync_ok), 0);

        // R7 direct loss after relock
        for (int k = 0; k < LOCK_N; k++) comma_at(2, 1'b0, "R3 relock");
        check(sync_ok == 1'b1, "R7 relocked", int'(sync_ok), 1);
        send_word(1'b1, 1'b0, "R7 bad");
        send_word(1'b0, 1'b1, "R7 bad");
        check(sync_ok == 1'b1, "R7 below threshold", int'(sync_ok), 1);
        send_word(1'b1, 1'b1, "R7 bad");
        check(sync_ok == 1'b0, "R7 loss at threshold", int'(sync_ok), 0);
        check(word_bnd == OW'(2), "R7 boundary retained", int'(word_bnd), 2);

        // R3 hit on a flagged word is not taken while hunting
        comma_at(4, 1'b1, "R3 flagged hit");
        check(word_bnd == OW'(2), "R3 flagged hit ignored", int'(word_bnd), 2);

        // R5 flagged hit at the stored offset clears the count
        comma_at(4, 1'b0, "R5 gather");
        check(word_bnd == OW'(4), "R5 new boundary", int'(word_bnd), 4);
        comma_at(4, 1'b0, "R5 gather");
        comma_at(4, 1'b1, "R5 coincide");
        comma_at(4, 1'b0, "R5 recount");
        comma_at(4, 1'b0, "R5 recount");
        check(sync_ok == 1'b0, "R5 count was cleared", int'(sync_ok), 0);
        comma_at(4, 1'b0, "R5 recount");
        check(sync_ok == 1'b1, "R5 lock after fresh run", int'(sync_ok), 1);

        // R10 idle with error flags while locked
        for (int k = 0; k < 5; k++) tick(1'b0, '0, 1'b1, 1'b1, "R10 idle locked");
        check(sync_ok == 1'b1, "R10 flags ignored when idle", int'(sync_ok), 1);

        // R2 R6 plain traffic keeps lock
        goods(6, "R6 steady");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule